// File: doc/BRIEF.md
# Funnel Double-Word Shifter with Carry Chaining

This block moves one 64-bit word left or right by 0 to 63 places. Vacated bit positions are filled from a separate carry-in word. The bits pushed out past the word boundary come back as a second result, the spill word. When the spill of one operation is fed into the carry-in of the next, software can shift a quantity of any length one word at a time, with no masking between steps.

A request is a single-cycle strobe with the operands, a direction select and a record select. The result, the spill and the optional 4-bit condition field are registered and appear one cycle later, together with a one-cycle done pulse.

In record mode the condition field reports the following:
- a signed comparison of the result with zero;
- an overflow bit that is set exactly when the spill word is nonzero.

The block has no output for any exception-register overflow or summary bit.

Top module: `dshift_unit`

## Requirements
- R1: The shift count n is amount_i[5:0]. Bits 63:6 of amount_i have no effect on any output.
- R2: Left mode (dir_right_i=0): result_o[i] = value_i[i-n] for i >= n, and result_o[i] = carry_i[i] for i < n.
- R3: Left mode: carry_o[i] = value_i[64-n+i] for i < n, and carry_o[i] = 0 for i >= n.
- R4: Right mode (dir_right_i=1): result_o[i] = value_i[i+n] for i < 64-n, and result_o[i] = carry_i[i] for i >= 64-n.
- R5: Right mode: carry_o[i] = value_i[i-64+n] for i >= 64-n, and carry_o[i] = 0 for i < 64-n.
- R6: With n = 0, result_o equals value_i and carry_o is zero in either direction. carry_i has no effect.
- R7: With record_i=1, cond_o[0] (overflow) is 1 if carry_o is nonzero and 0 if it is zero.
- R8: With record_i=1, cond_o[3] (less), cond_o[2] (greater) and cond_o[1] (equal) give the signed comparison of result_o with zero. Exactly one of them is set, and cond_valid_o is 1.
- R9: With record_i=0, cond_o is 4'b0000 and cond_valid_o is 0.
- R10: Outputs update on the first rising edge after a cycle with valid_i=1. done_o is high for exactly that one cycle. Without a request, all data outputs hold their values.
- R11: If the words are processed from least significant upward for a left shift (most significant downward for a right shift), and each carry_o is fed into the next carry_i starting from zero, the outputs form the shifted multi-word quantity.
- R12: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| dir_right_i | input | 1 | 0 = left shift, 1 = right shift |
| record_i | input | 1 | Produce the condition field |
| value_i | input | 64 | Word to shift |
| amount_i | input | 64 | Shift-amount operand, low 6 bits used |
| carry_i | input | 64 | Fill word for vacated bits |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 64 | Shifted word |
| carry_o | output | 64 | Spill word |
| cond_o | output | 4 | {less, greater, equal, overflow} |
| cond_valid_o | output | 1 | Condition field is meaningful |

## Verification
The following are checked by assertions on every cycle:
- the done pulse tracks the request one cycle later;
- outputs stay stable when there is no request;
- the overflow bit matches a nonzero spill;
- exactly one comparison bit is set in record mode;
- the condition field is cleared outside record mode;
- a zero count passes the value through with an empty spill.

The bit placement for each direction and count cannot be expressed compactly as a property. The scoreboard covers it against a bitwise model, with boundary counts 0, 1 and 63, and with ignored high bits in the amount operand. Only the scenarios can show multi-word chaining in both directions and the reset state.

// File: rtl/dshift_pkg.sv
package dshift_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } dir_e;

  localparam int unsigned COND_W = 4;
  localparam int unsigned CB_LT = 3;
  localparam int unsigned CB_GT = 2;
  localparam int unsigned CB_EQ = 1;
  localparam int unsigned CB_OV = 0;
endpackage

// File: rtl/dshift_core.sv
module dshift_core #(
  parameter int unsigned W  = 64,
  parameter int unsigned SW = $clog2(W)
) (
  input  dshift_pkg::dir_e dir_i,
  input  logic [W-1:0]     value_i,
  input  logic [W-1:0]     carry_i,
  input  logic [SW-1:0]    shamt_i,
  output logic [W-1:0]     result_o,
  output logic [W-1:0]     spill_o
);
  import dshift_pkg::*;

  logic [2*W-1:0] wide_l, wide_r;
  logic [W-1:0]   fill_l, fill_r;

  // funnel: zero-extended double word, the discarded half is the spill
  always_comb begin
    wide_l = {{W{1'b0}}, value_i} << shamt_i;
    wide_r = {value_i, {W{1'b0}}} >> shamt_i;
    fill_l = carry_i & ~({W{1'b1}} << shamt_i);
    fill_r = carry_i & ~({W{1'b1}} >> shamt_i);
    if (dir_i == DIR_LEFT) begin
      result_o = wide_l[W-1:0] | fill_l;
      spill_o  = wide_l[2*W-1:W];
    end else begin
      result_o = wide_r[2*W-1:W] | fill_r;
      spill_o  = wide_r[W-1:0];
    end
  end
endmodule

// File: rtl/dshift_cond.sv
module dshift_cond #(
  parameter int unsigned W = 64
) (
  input  logic                          record_i,
  input  logic [W-1:0]                  result_i,
  input  logic [W-1:0]                  spill_i,
  output logic [dshift_pkg::COND_W-1:0] cond_o,
  output logic                          cond_valid_o
);
  import dshift_pkg::*;

  logic is_zero, is_neg;

  always_comb begin
    is_zero = (result_i == '0);
    is_neg  = result_i[W-1];
    cond_o  = '0;
    if (record_i) begin
      cond_o[CB_LT] = is_neg;
      cond_o[CB_GT] = !is_neg && !is_zero;
      cond_o[CB_EQ] = is_zero;
      cond_o[CB_OV] = (spill_i != '0);
    end
    cond_valid_o = record_i;
  end
endmodule

// File: rtl/dshift_unit.sv
module dshift_unit #(
  parameter int unsigned W = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          dir_right_i,
  input  logic                          record_i,
  input  logic [W-1:0]                  value_i,
  input  logic [W-1:0]                  amount_i,
  input  logic [W-1:0]                  carry_i,
  output logic                          done_o,
  output logic [W-1:0]                  result_o,
  output logic [W-1:0]                  carry_o,
  output logic [dshift_pkg::COND_W-1:0] cond_o,
  output logic                          cond_valid_o
);
  import dshift_pkg::*;

  localparam int unsigned SW = $clog2(W);

  logic [SW-1:0]     shamt;
  logic [W-1:0]      res_d, spill_d;
  logic [COND_W-1:0] cond_d;
  logic              cvld_d;
  logic              unused_amount_hi;
  dir_e              dir;

  assign shamt            = amount_i[SW-1:0];
  assign unused_amount_hi = ^amount_i[W-1:SW];
  assign dir              = dir_right_i ? DIR_RIGHT : DIR_LEFT;

  dshift_core #(.W(W), .SW(SW)) i_core (
    .dir_i    (dir),
    .value_i  (value_i),
    .carry_i  (carry_i),
    .shamt_i  (shamt),
    .result_o (res_d),
    .spill_o  (spill_d)
  );

  dshift_cond #(.W(W)) i_cond (
    .record_i     (record_i),
    .result_i     (res_d),
    .spill_i      (spill_d),
    .cond_o       (cond_d),
    .cond_valid_o (cvld_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      result_o     <= '0;
      carry_o      <= '0;
      cond_o       <= '0;
      cond_valid_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        result_o     <= res_d;
        carry_o      <= spill_d;
        cond_o       <= cond_d;
        cond_valid_o <= cvld_d;
      end
    end
  end
endmodule

// File: rtl/dshift_unit_chk.sv
module dshift_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] value_i,
  input logic [W-1:0] amount_i,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic [W-1:0] carry_o,
  input logic [3:0]   cond_o,
  input logic         cond_valid_o
);
  localparam int unsigned SW = $clog2(W);

  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(carry_o) && $stable(cond_o))); // R10
  AST_OVERFLOW_SPILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_valid_o |-> (cond_o[0] == (carry_o != '0))); // R7
  AST_ONE_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_valid_o |-> ($countones(cond_o[3:1]) == 1)); // R8
  AST_NO_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_valid_o |-> (cond_o == 4'b0000)); // R9
  AST_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amount_i[SW-1:0] == '0) |=>
      (result_o == $past(value_i) && carry_o == '0)); // R6
endmodule

bind dshift_unit dshift_unit_chk #(.W(W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .value_i      (value_i),
  .amount_i     (amount_i),
  .done_o       (done_o),
  .result_o     (result_o),
  .carry_o      (carry_o),
  .cond_o       (cond_o),
  .cond_valid_o (cond_valid_o)
);

// File: tb/test_dshift_unit.sv
`timescale 1ns/1ps
module test_dshift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dir_right_i = 1'b0;
  logic        record_i = 1'b0;
  logic [63:0] value_i = '0, amount_i = '0, carry_i = '0;
  logic        done_o;
  logic [63:0] result_o, carry_o;
  logic [3:0]  cond_o;
  logic        cond_valid_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [63:0] res;
    logic [63:0] spill;
    logic [3:0]  cond;
    logic        cvld;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk_i = ~clk_i;

  dshift_unit i_dshift_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dir_right_i(dir_right_i),
    .record_i(record_i), .value_i(value_i), .amount_i(amount_i), .carry_i(carry_i),
    .done_o(done_o), .result_o(result_o), .carry_o(carry_o), .cond_o(cond_o),
    .cond_valid_o(cond_valid_o)
  );

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bitwise reference model
  function automatic exp_t model(logic dr, logic rec, logic [63:0] a,
                                 logic [63:0] amt, logic [63:0] c);
    exp_t e;
    int n;
    n = int'(amt[5:0]);
    e.res = '0;
    e.spill = '0;
    for (int i = 0; i < 64; i++) begin
      if (!dr) begin
        e.res[i] = (i >= n) ? a[i-n] : c[i];
        if (i < n) e.spill[i] = a[64-n+i];
      end else begin
        e.res[i] = (i < 64-n) ? a[i+n] : c[i];
        if (i >= 64-n) e.spill[i] = a[i-64+n];
      end
    end
    e.cvld = rec;
    e.cond = rec ? {e.res[63], (!e.res[63] && e.res != 0), (e.res == 0), (e.spill != 0)} : 4'b0;
    if (n == 0) e.tag = "R6";
    else e.tag = dr ? "R4/R5" : "R2/R3";
    return e;
  endfunction

  // driver: one-cycle request, expectation pushed to scoreboard
  task automatic drive(logic dr, logic rec, logic [63:0] a, logic [63:0] amt,
                       logic [63:0] c, string extra = "");
    exp_t e;
    @(negedge clk_i);
    e = model(dr, rec, a, amt, c);
    if (extra != "") e.tag = {extra, " ", e.tag};
    sb_q.push_back(e);
    valid_i = 1'b1; dir_right_i = dr; record_i = rec;
    value_i = a; amount_i = amt; carry_i = c;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        if (sb_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R10 unexpected done act=1 exp=0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check64({e.tag, " result"}, result_o, e.res);
          check64({e.tag, " spill"}, carry_o, e.spill);
          check64(e.cvld ? "R7/R8 cond" : "R9 cond", {60'b0, cond_o}, {60'b0, e.cond});
          check64(e.cvld ? "R8 cond_valid" : "R9 cond_valid", {63'b0, cond_valid_o}, {63'b0, e.cvld});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [255:0] big, big_exp;
  logic [63:0]  cin, held;

  initial begin
    #1;
    // R12 reset state
    check64("R12 result", result_o, '0);
    check64("R12 spill", carry_o, '0);
    check64("R12 cond/done", {58'b0, cond_o, cond_valid_o, done_o}, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    drive(0, 1, 64'h0123_4567_89AB_CDEF, 64'd8,  64'hFFFF_FFFF_FFFF_FF5A);
    drive(1, 1, 64'h0123_4567_89AB_CDEF, 64'd8,  64'hA5FF_FFFF_FFFF_FFFF);
    drive(0, 1, 64'h8000_0000_0000_0001, 64'd1,  64'h0);
    drive(1, 1, 64'h8000_0000_0000_0001, 64'd1,  64'hFFFF_FFFF_FFFF_FFFF);
    drive(0, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'd63, 64'h1234_5678_9ABC_DEF0);
    drive(1, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'd63, 64'h1234_5678_9ABC_DEF0);
    drive(0, 1, 64'h5555_0000_0000_0000, 64'd0,  64'hFFFF_FFFF_FFFF_FFFF);
    drive(1, 1, 64'h0000_0000_0000_0000, 64'd0,  64'h8000_0000_0000_0000);
    drive(0, 1, 64'h0,                   64'd20, 64'h0, "R8 eq");
    drive(1, 0, 64'hF0F0_F0F0_F0F0_F0F0, 64'd12, 64'h7, "R9");
    drive(0, 1, 64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFC5, 64'h0, "R1");
    drive(1, 1, 64'hFF00_0000_0000_0000, 64'hAAAA_AAAA_AAAA_AA44, 64'h0, "R1");

    // R10: idle hold
    @(negedge clk_i);
    held = result_o;
    repeat (4) @(negedge clk_i);
    check64("R10 hold result", result_o, held);
    check64("R10 done low", {63'b0, done_o}, '0);

    // R11: left chain, 4 words by 13
    big = {64'h8123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_1E1E_2D2D_3C3C, 64'hC000_0000_0000_0003};
    big_exp = big << 13;
    cin = '0;
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, big[64*k +: 64], 64'd13, cin, "R11");
      check64("R11 left word", result_o, big_exp[64*k +: 64]);
      cin = carry_o;
    end
    // R11: right chain, 4 words by 50
    big_exp = big >> 50;
    cin = '0;
    for (int k = 3; k >= 0; k--) begin
      drive(1, 0, big[64*k +: 64], 64'd50, cin, "R11");
      check64("R11 right word", result_o, big_exp[64*k +: 64]);
      cin = carry_o;
    end

    repeat (3) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R10 missing done act=%0d exp=0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule